// File: doc/BRIEF.md
# PCIe Address Translation Window Unit

This block translates addresses for a PCIe root port. It holds two banks of translation windows. One bank serves traffic from the CPU toward the link (outbound), and the other serves traffic from the link toward memory (inbound). Software programs the windows over a 32-bit register bus. A selector register chooses one window by index and direction, and all per-window registers then act on that window. The window settings move into the matching logic only when its second control register is written. That write is the commit point, so a window can be rebuilt field by field without ever exposing a half-written window to traffic.

Translation requests arrive on a valid/ready stream carrying a 64-bit address and a direction bit. Each request is matched against the enabled windows of its direction, and one result per request leaves on a second valid/ready stream. A memory-type window returns `target + (addr - base)`. A config-type window returns a configuration request instead: the bus and device/function numbers come from the window's target register, and the register offset comes from the address. Results leave in request order. Back-pressure is supported: while `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and `req_ready` is low. A new request is taken in any cycle in which the output stage is empty or is being drained.

Top module: `pcie_xlat_unit`

## Requirements
- R1: The selector register at offset 0x900 reads back the last 32-bit value written to it. Its bits [3:0] give the window index, and its bit 31 gives the direction (1 inbound, 0 outbound).
- R2: The per-window registers of the selected window sit at these offsets: 0x904 type, 0x908 control, 0x90C base bits [31:0], 0x910 base bits [63:32], 0x914 limit (32 bits), 0x918 target bits [31:0], 0x91C target bits [63:32]. Writing one half of base or target leaves the other half unchanged.
- R3: After reset, every window has base 0, target 0, limit 0xFFFFFFFF, type 0 and control 0. The exception is inbound window 0, whose control reads 0x80000000. That window is active, so an inbound address up to 0xFFFFFFFF comes back as a hit with the same address.
- R4: Writes to type, base, limit or target change no translation result until the control register of that window is written. The control write activates the window's current settings, with bit 31 as the enable.
- R5: An enabled window matches an address A when base <= A <= {base[63:32], limit}. A memory-type window (type value 0) returns hit=1, cfg=0 and address target + (A - base).
- R6: A window whose type value is nonzero is a config window. On a match it returns hit=1, cfg=1, bus = target[31:24], devfn = target[23:16], register offset = (A - base)[11:0], and address 0.
- R7: When several enabled windows of the same direction match, the window with the lowest index supplies the result.
- R8: When no enabled window of the request's direction matches, the result has hit=0 and all other result fields zero.
- R9: A result appears on the output stream in the cycle after its request is accepted. Results keep request order. While rsp_valid=1 and rsp_ready=0, the result stays stable and req_ready=0.
- R10: While the selector index is not below NUM_WIN, per-window writes change no window and per-window reads return 0. Any offset that is not mapped also reads 0.
- R11: reg_rdata holds the read value from the clock edge that samples reg_rd onward, and it keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translation request accepted when high with req_valid |
| req_inbound | input | 1 | Request direction, 1 = inbound |
| req_addr | input | 64 | Address to translate |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_hit | output | 1 | A window matched |
| rsp_cfg | output | 1 | Result is a configuration request |
| rsp_addr | output | 64 | Translated memory address |
| rsp_bus | output | 8 | Config request bus number |
| rsp_devfn | output | 8 | Config request device/function |
| rsp_regoff | output | 12 | Config request register offset |

## Verification
A request accepted at clock edge N shows its result on the output registers right after edge N. The monitor therefore compares it at the falling edge that follows. Expected results are queued at the moment of acceptance, using a model of the windows that changes only on control writes. Read data is registered at the edge that samples reg_rd, so each read is checked at the next falling edge. A control write takes effect at its own edge, so a request driven in the following cycle already sees the new window. During stalls the monitor compares each held result against its value from the previous cycle.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int REG_AW    = 12;
  localparam int XADDR_W   = 64;
  localparam int CFG_OFF_W = 12;

  localparam logic [REG_AW-1:0] OFF_SEL     = 12'h900;
  localparam logic [REG_AW-1:0] OFF_TYPE    = 12'h904;
  localparam logic [REG_AW-1:0] OFF_CTRL    = 12'h908;
  localparam logic [REG_AW-1:0] OFF_BASE_LO = 12'h90C;
  localparam logic [REG_AW-1:0] OFF_BASE_HI = 12'h910;
  localparam logic [REG_AW-1:0] OFF_LIMIT   = 12'h914;
  localparam logic [REG_AW-1:0] OFF_TGT_LO  = 12'h918;
  localparam logic [REG_AW-1:0] OFF_TGT_HI  = 12'h91C;

  typedef struct packed {
    logic [XADDR_W-1:0] base;
    logic [31:0]        limit;
    logic [XADDR_W-1:0] target;
    logic               is_cfg;
    logic               en;
  } win_t;

  typedef struct packed {
    logic                 hit;
    logic                 is_cfg;
    logic [XADDR_W-1:0]   addr;
    logic [7:0]           bus;
    logic [7:0]           devfn;
    logic [CFG_OFF_W-1:0] off;
  } xlat_t;
endpackage

// File: rtl/pxu_regfile.sv
module pxu_regfile
  import pxu_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [REG_AW-1:0]         reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output win_t [NUM_WIN-1:0]        act_out,
  output win_t [NUM_WIN-1:0]        act_in
);
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [31:0]        sel_q;
  logic [XADDR_W-1:0] base_q   [2][NUM_WIN];
  logic [31:0]        limit_q  [2][NUM_WIN];
  logic [XADDR_W-1:0] tgt_q    [2][NUM_WIN];
  logic [31:0]        type_q   [2][NUM_WIN];
  logic [31:0]        ctrl_q   [2][NUM_WIN];
  win_t               act_q    [2][NUM_WIN];

  logic             sel_dir;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_ok;
  logic [31:0]      rd_next;

  assign sel_dir = sel_q[31];
  assign sel_idx = sel_q[IDX_W-1:0];
  assign sel_ok  = (int'(sel_q[3:0]) < NUM_WIN);

  // Programming copies plus the committed (active) copy per window.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int d = 0; d < 2; d++) begin
        for (int w = 0; w < NUM_WIN; w++) begin
          base_q[d][w]  <= '0;
          limit_q[d][w] <= '1;
          tgt_q[d][w]   <= '0;
          type_q[d][w]  <= '0;
          ctrl_q[d][w]  <= (d == 1 && w == 0) ? 32'h8000_0000 : 32'h0;
          act_q[d][w]   <= win_t'{base: '0, limit: '1, target: '0,
                                  is_cfg: 1'b0, en: (d == 1 && w == 0)};
        end
      end
    end else if (reg_wr) begin
      if (reg_addr == OFF_SEL) sel_q <= reg_wdata;
      if (sel_ok) begin
        unique case (reg_addr)
          OFF_TYPE:    type_q[sel_dir][sel_idx] <= reg_wdata;
          OFF_CTRL: begin
            ctrl_q[sel_dir][sel_idx] <= reg_wdata;
            act_q[sel_dir][sel_idx]  <= win_t'{
              base:   base_q[sel_dir][sel_idx],
              limit:  limit_q[sel_dir][sel_idx],
              target: tgt_q[sel_dir][sel_idx],
              is_cfg: (type_q[sel_dir][sel_idx] != 32'h0),
              en:     reg_wdata[31]};
          end
          OFF_BASE_LO: base_q[sel_dir][sel_idx][31:0]  <= reg_wdata;
          OFF_BASE_HI: base_q[sel_dir][sel_idx][63:32] <= reg_wdata;
          OFF_LIMIT:   limit_q[sel_dir][sel_idx]       <= reg_wdata;
          OFF_TGT_LO:  tgt_q[sel_dir][sel_idx][31:0]   <= reg_wdata;
          OFF_TGT_HI:  tgt_q[sel_dir][sel_idx][63:32]  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (reg_addr == OFF_SEL) begin
      rd_next = sel_q;
    end else if (sel_ok) begin
      unique case (reg_addr)
        OFF_TYPE:    rd_next = type_q[sel_dir][sel_idx];
        OFF_CTRL:    rd_next = ctrl_q[sel_dir][sel_idx];
        OFF_BASE_LO: rd_next = base_q[sel_dir][sel_idx][31:0];
        OFF_BASE_HI: rd_next = base_q[sel_dir][sel_idx][63:32];
        OFF_LIMIT:   rd_next = limit_q[sel_dir][sel_idx];
        OFF_TGT_LO:  rd_next = tgt_q[sel_dir][sel_idx][31:0];
        OFF_TGT_HI:  rd_next = tgt_q[sel_dir][sel_idx][63:32];
        default:     rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_out
    assign act_out[w] = act_q[0][w];
    assign act_in[w]  = act_q[1][w];
  end

  logic ctrl_wr;
  logic sel_act_en;
  assign ctrl_wr    = reg_wr && sel_ok && (reg_addr == OFF_CTRL);
  assign sel_act_en = act_q[sel_dir][sel_idx].en;

  AST_COMMIT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> sel_act_en == $past(reg_wdata[31])); // R4
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == OFF_SEL) |=> $stable(sel_q)); // R1
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !sel_ok && reg_addr != OFF_SEL) |=> reg_rdata == 32'h0); // R10
endmodule

// File: rtl/pxu_match.sv
module pxu_match
  import pxu_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  win_t [NUM_WIN-1:0] wins,
  input  logic [XADDR_W-1:0] addr,
  output xlat_t              res
);
  logic [NUM_WIN-1:0] in_range;
  logic [NUM_WIN-1:0] pick;
  logic [XADDR_W-1:0] delta [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [XADDR_W-1:0] top_addr;
    assign top_addr    = {wins[w].base[XADDR_W-1:32], wins[w].limit};
    assign delta[w]    = addr - wins[w].base;
    assign in_range[w] = wins[w].en && (addr >= wins[w].base) && (addr <= top_addr);
  end

  // Lowest index wins.
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      pick[w] = in_range[w] && !found;
      found   = found || in_range[w];
    end
  end

  always_comb begin
    res = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (pick[w]) begin
        res.hit = 1'b1;
        if (wins[w].is_cfg) begin
          res.is_cfg = 1'b1;
          res.bus    = wins[w].target[31:24];
          res.devfn  = wins[w].target[23:16];
          res.off    = delta[w][CFG_OFF_W-1:0];
        end else begin
          res.addr = wins[w].target + delta[w];
        end
      end
    end
  end

  AST_PICK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick)); // R7
  AST_NO_RANGE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_range == '0) |-> (!res.hit && res.addr == '0)); // R8
endmodule

// File: rtl/pxu_pipe.sv
module pxu_pipe
  import pxu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  xlat_t in_data,
  output logic  out_valid,
  input  logic  out_ready,
  output xlat_t out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
  AST_STALL_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9
endmodule

// File: rtl/pcie_xlat_unit.sv
module pcie_xlat_unit
  import pxu_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_inbound,
  input  logic [XADDR_W-1:0]   req_addr,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_hit,
  output logic                 rsp_cfg,
  output logic [XADDR_W-1:0]   rsp_addr,
  output logic [7:0]           rsp_bus,
  output logic [7:0]           rsp_devfn,
  output logic [CFG_OFF_W-1:0] rsp_regoff
);
  win_t [NUM_WIN-1:0] act_out;
  win_t [NUM_WIN-1:0] act_in;
  win_t [NUM_WIN-1:0] wins_sel;
  xlat_t              match_res;
  xlat_t              rsp_q;

  pxu_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .act_out(act_out), .act_in(act_in)
  );

  assign wins_sel = req_inbound ? act_in : act_out;

  pxu_match #(.NUM_WIN(NUM_WIN)) u_match (
    .clk(clk), .rst_n(rst_n), .wins(wins_sel), .addr(req_addr), .res(match_res)
  );

  pxu_pipe u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(match_res),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(rsp_q)
  );

  assign rsp_hit    = rsp_q.hit;
  assign rsp_cfg    = rsp_q.is_cfg;
  assign rsp_addr   = rsp_q.addr;
  assign rsp_bus    = rsp_q.bus;
  assign rsp_devfn  = rsp_q.devfn;
  assign rsp_regoff = rsp_q.off;

  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_cfg && rsp_addr == '0 && rsp_bus == 8'h0
                                 && rsp_devfn == 8'h0 && rsp_regoff == '0)); // R8
  AST_CFG_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cfg) |-> (rsp_hit && rsp_addr == '0)); // R6
endmodule

// File: tb/sim_pcie_xlat_unit.sv
module sim_pcie_xlat_unit;
  localparam int NW = 4;

  typedef struct packed {
    logic        hit;
    logic        cfg;
    logic [63:0] addr;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [11:0] off;
  } res_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic req_valid = 1'b0, req_ready, req_inbound = 1'b0;
  logic [63:0] req_addr = '0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_hit, rsp_cfg;
  logic [63:0] rsp_addr;
  logic [7:0] rsp_bus, rsp_devfn;
  logic [11:0] rsp_regoff;

  always #4 clk = ~clk;

  pcie_xlat_unit #(.NUM_WIN(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_inbound(req_inbound),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_cfg(rsp_cfg), .rsp_addr(rsp_addr),
    .rsp_bus(rsp_bus), .rsp_devfn(rsp_devfn), .rsp_regoff(rsp_regoff)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;

  // Model: programming copies and committed copies of the windows.
  logic [31:0] m_sel = '0;
  logic [63:0] p_base [2][NW], p_tgt [2][NW], a_base [2][NW], a_tgt [2][NW];
  logic [31:0] p_lim [2][NW], p_type [2][NW], a_lim [2][NW];
  bit a_cfg [2][NW], a_en [2][NW];

  res_t  expq [$];
  string tagq [$];

  task automatic model_reset();
    m_sel = '0;
    for (int d = 0; d < 2; d++)
      for (int w = 0; w < NW; w++) begin
        p_base[d][w] = '0; p_tgt[d][w] = '0; p_lim[d][w] = '1; p_type[d][w] = '0;
        a_base[d][w] = '0; a_tgt[d][w] = '0; a_lim[d][w] = '1;
        a_cfg[d][w] = 1'b0; a_en[d][w] = (d == 1 && w == 0);
      end
  endtask

  function automatic res_t predict(input bit dir, input logic [63:0] a);
    res_t r;
    r = '0;
    for (int w = 0; w < NW; w++) begin
      if (a_en[dir][w] && a >= a_base[dir][w] && a <= {a_base[dir][w][63:32], a_lim[dir][w]}) begin
        r.hit = 1'b1;
        if (a_cfg[dir][w]) begin
          r.cfg = 1'b1; r.bus = a_tgt[dir][w][31:24]; r.devfn = a_tgt[dir][w][23:16];
          r.off = 12'((a - a_base[dir][w]) & 64'hFFF);
        end else begin
          r.addr = a_tgt[dir][w] + (a - a_base[dir][w]);
        end
        return r;
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    bit ok;
    int d, w;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    ok = (m_sel[3:0] < NW); d = int'(m_sel[31]); w = int'(m_sel[3:0]);
    if (a == 12'h900) m_sel = v;
    else if (ok) begin
      case (a)
        12'h904: p_type[d][w] = v;
        12'h908: begin
          a_base[d][w] = p_base[d][w]; a_tgt[d][w] = p_tgt[d][w]; a_lim[d][w] = p_lim[d][w];
          a_cfg[d][w] = (p_type[d][w] != 0); a_en[d][w] = v[31];
        end
        12'h90C: p_base[d][w][31:0] = v;
        12'h910: p_base[d][w][63:32] = v;
        12'h914: p_lim[d][w] = v;
        12'h918: p_tgt[d][w][31:0] = v;
        12'h91C: p_tgt[d][w][63:32] = v;
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic send(input bit dir, input logic [63:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_inbound = dir; req_addr = a;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    expq.push_back(predict(dir, a));
    tagq.push_back(tag);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: consumes results, applies back-pressure, checks order and hold.
  bit   stall_prev = 1'b0;
  res_t held;
  always @(negedge clk) begin
    res_t got, e;
    string t;
    if (rst_n) begin
      cyc++;
      rsp_ready = !(bp_on && (cyc % 3 == 0));
      got = '{rsp_hit, rsp_cfg, rsp_addr, rsp_bus, rsp_devfn, rsp_regoff};
      if (stall_prev) check(rsp_valid && got == held, "R9 held result", 64'(got), 64'(held));
      if (rsp_valid && rsp_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9 unexpected result", 64'(got), 64'h0);
        end else begin
          e = expq.pop_front();
          t = tagq.pop_front();
          check(got == e, t, got.addr ^ {got.hit, got.cfg, 54'h0, got.off[7:0]},
                e.addr ^ {e.hit, e.cfg, 54'h0, e.off[7:0]});
          check(got.bus == e.bus && got.devfn == e.devfn && got.off == e.off,
                t, {40'h0, got.bus, got.devfn, got.off[7:0]}, {40'h0, e.bus, e.devfn, e.off[7:0]});
        end
      end
      stall_prev = rsp_valid && !rsp_ready;
      held = got;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset values; R1 selector at 0.
    check(rsp_valid == 1'b0 && reg_rdata == 32'h0, "R3 reset outputs", 64'(rsp_valid), 64'h0);
    rd(12'h900, 32'h0, "R1 selector reset");
    rd(12'h908, 32'h0, "R3 outbound0 control reset");
    rd(12'h914, 32'hFFFF_FFFF, "R3 limit reset");
    wr(12'h900, 32'h8000_0000);
    rd(12'h908, 32'h8000_0000, "R3 inbound0 control reset");
    rd(12'h90C, 32'h0, "R3 base reset");
    rd(12'h11, 32'h0, "R10 unmapped offset R11");
    send(1'b1, 64'h1234_5678, "R3 inbound passthrough");
    send(1'b1, 64'hFFFF_FFFF, "R3 inbound top edge");
    send(1'b1, 64'h1_0000_0000, "R8 inbound above limit");
    send(1'b0, 64'h1000, "R8 outbound miss after reset");
    drain();

    // Outbound window 1: memory type, program then commit.
    wr(12'h900, 32'h0000_0001);
    rd(12'h900, 32'h0000_0001, "R1 selector readback");
    wr(12'h90C, 32'h2000_0000);
    wr(12'h910, 32'h0000_0001);
    wr(12'h914, 32'h2FFF_FFFF);
    wr(12'h918, 32'h0000_0000);
    wr(12'h91C, 32'h0000_00AB);
    send(1'b0, 64'h1_2000_0010, "R4 no effect before commit");
    drain();
    rd(12'h910, 32'h1, "R2 base high");
    rd(12'h90C, 32'h2000_0000, "R2 base low");
    rd(12'h91C, 32'hAB, "R2 target high");
    wr(12'h908, 32'h8000_0000);
    rd(12'h908, 32'h8000_0000, "R2 control readback");
    send(1'b0, 64'h1_2000_0010, "R5 memory translate");
    send(1'b0, 64'h1_2FFF_FFFF, "R5 upper bound hit");
    send(1'b0, 64'h1_3000_0000, "R5 above bound miss");
    send(1'b0, 64'h1_1FFF_FFFF, "R5 below base miss");
    send(1'b0, 64'h1_2000_0000, "R5 base hit");
    drain();
    wr(12'h918, 32'h0000_1111);
    rd(12'h91C, 32'hAB, "R2 half write keeps high");
    rd(12'h918, 32'h1111, "R2 target low");

    // Outbound window 0: config type.
    wr(12'h900, 32'h0000_0000);
    wr(12'h90C, 32'h4000_0000);
    wr(12'h914, 32'h4FFF_FFFF);
    wr(12'h918, 32'h0312_0000);
    wr(12'h904, 32'h0000_0004);
    wr(12'h908, 32'h8000_0000);
    rd(12'h904, 32'h4, "R2 type readback");
    send(1'b0, 64'h4000_0ABC, "R6 config request");
    send(1'b0, 64'h4001_2345, "R6 config offset wraps");
    drain();

    // Outbound window 2 overlaps window 0.
    wr(12'h900, 32'h0000_0002);
    wr(12'h90C, 32'h4000_0000);
    wr(12'h914, 32'h4000_FFFF);
    wr(12'h918, 32'h9000_0000);
    wr(12'h908, 32'h8000_0000);
    send(1'b0, 64'h4000_0010, "R7 lowest index wins");
    drain();
    wr(12'h900, 32'h0000_0000);
    wr(12'h908, 32'h0000_0000);
    send(1'b0, 64'h4000_0010, "R7 next window after disable");
    drain();
    wr(12'h900, 32'h0000_0002);
    wr(12'h918, 32'hA000_0000);
    send(1'b0, 64'h4000_0010, "R4 target change not committed");
    drain();
    wr(12'h908, 32'h8000_0000);
    send(1'b0, 64'h4000_0010, "R4 target change committed");
    drain();

    // Inbound window 2 programmed separately from outbound 2.
    wr(12'h900, 32'h8000_0002);
    rd(12'h900, 32'h8000_0002, "R1 inbound selector");
    wr(12'h90C, 32'h0000_5555);
    wr(12'h900, 32'h0000_0002);
    rd(12'h90C, 32'h4000_0000, "R1 direction bit separates banks");

    // Out-of-range index.
    wr(12'h900, 32'h0000_0005);
    wr(12'h90C, 32'h0000_FFFF);
    wr(12'h908, 32'h0000_0000);
    rd(12'h90C, 32'h0, "R10 out-of-range read");
    rd(12'h908, 32'h0, "R10 out-of-range control read");
    wr(12'h900, 32'h0000_0001);
    rd(12'h90C, 32'h2000_0000, "R10 write ignored");
    send(1'b0, 64'h1_2000_0020, "R10 window 1 still active");
    drain();

    // Back-pressure burst.
    bp_on = 1'b1;
    for (int i = 0; i < 12; i++)
      send(1'b0, 64'h1_2000_0000 + 64'(i * 64'h100), "R9 burst order");
    send(1'b0, 64'h7, "R9 burst miss");
    send(1'b1, 64'h42, "R9 burst inbound");
    drain();
    bp_on = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule